// File: doc/BRIEF.md
# Multiprocessor Interrupt Dispatch Controller

This block gathers interrupt sources for a group of up to four processors and drives three interrupt lines to each of them. The three lines are device, timer and inter-processor. A vector of device interrupt requests is registered every cycle. Each processor has its own device mask. When a processor's mask is written, the block stores that processor's masked view, which is the new mask ANDed with the registered request vector. The processor's device line is the OR of its stored view.

Inter-processor interrupts are posted and cleared by bus writes. They can be written as packed fields of one shared control word, or through dedicated set and clear registers that take a processor bit mask. A periodic timer tick sets a pending timer interrupt for every processor. Software clears timer interrupts processor by processor.

The bus accepts only 64-bit accesses. Every request gets a response one cycle later. Improper accesses are flagged and change no state.

Top module: `irq_dispatch`

## Requirements
- R1: The register index is `req_addr[9:6]`. Each register occupies its own 64-byte slot, and address bits 5:0 are ignored. The indices are: 0 control, 1 status, 2 raw request, 3 inter-processor set, 4 inter-processor clear, 5 timer clear, 8+n mask of processor n, 12+n masked view of processor n.
- R2: Only `req_size` = 3 (8 bytes) is legal. Any other size returns `rsp_err`=1 with read data 0, and no state changes.
- R3: Every request with `req_valid` gets `rsp_valid` exactly one cycle later, together with `rsp_rdata` and `rsp_err`. `rsp_err` is never high without `rsp_valid`.
- R4: A write to mask n stores the data as the mask. It also stores the view as the data ANDed with the registered request vector, which holds `dev_req` from the previous edge. `irq_dev[n]` is the OR of that view, so it rises when a view bit goes from 0 to 1 and falls when the last set bit clears. Both the mask and the view read back.
- R5: The view is recomputed only on a mask write. A change of `dev_req` alone leaves every view and `irq_dev` unchanged.
- R6: In a control write, bits 15:12 set the pending inter-processor interrupt of each flagged processor. Bits 11:8 clear it, and bits 7:4 clear the pending timer interrupt. Within one write, clears take effect before sets. `irq_ipi` and `irq_tmr` show the pending bits.
- R7: The sticky warning flag (status bit 0) is set in two cases: a set request for a processor whose inter-processor bit is pending and is not cleared in the same write, or a clear for a processor with nothing pending. The pending state follows R6 unchanged. Writing 1 to status bit 0 clears the flag.
- R8: `timer_tick` sets the pending timer bit of every processor. When a tick and a timer clear fall in the same cycle, the tick wins.
- R9: Bit 28 of a control write is accepted without error and has no other effect.
- R10: Registers 3, 4 and 5 take a processor bit mask in bits 3:0 and apply set, clear or timer clear, following the same warning rules. A write of all zeros to any of them returns `rsp_err` and changes nothing.
- R11: Reading the control register returns pending inter-processor bits in 11:8, pending timer bits in 7:4, and `req_cpu` in 1:0. Reading register 2 returns the registered request vector.
- R12: Synchronous active-low reset clears masks, views, pending bits, the warning flag and all outputs.
- R13: An unmapped index (6, 7) or a write to a read-only register (2, 12 to 15) returns `rsp_err` and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 10 | Byte offset of the access |
| req_size | input | 2 | Access size as log2 of bytes |
| req_wdata | input | 64 | Write data |
| req_cpu | input | 2 | ID of the processor making the request |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 64 | Read data |
| dev_req | input | 64 | Raw device interrupt request vector |
| timer_tick | input | 1 | Periodic timer pulse |
| irq_dev | output | 4 | Device interrupt line per processor |
| irq_tmr | output | 4 | Timer interrupt line per processor |
| irq_ipi | output | 4 | Inter-processor interrupt line per processor |

## Verification
The collision that matters is a timer tick landing in the same cycle as a bus write that clears timer interrupts. The bench provokes it by raising `timer_tick` on the very cycle a control write carries clear bits 7:4. It then checks that every timer line is still set afterwards. A second same-cycle case is a single control write that both clears and sets one processor's inter-processor bit. The bench judges it by checking that the line stays pending and that the warning flag stays clear.

// File: rtl/irq_dispatch_pkg.sv
// Package: shared constants for the interrupt dispatch controller.
// Assumes at most four processors, so each control field fits a nibble.
package irq_dispatch_pkg;
    localparam int          REG_IDX_LSB     = 6;   // 64-byte register slots
    localparam int          REG_IDX_W       = 4;
    localparam int          CTL_IPI_SET_LSB = 12;
    localparam int          CTL_IPI_CLR_LSB = 8;
    localparam int          CTL_TMR_CLR_LSB = 4;
    localparam int          CTL_ID_LSB      = 0;
    localparam logic [1:0]  SIZE_DWORD      = 2'd3;

    typedef enum logic [REG_IDX_W-1:0] {
        RG_CTRL    = 4'd0,
        RG_STAT    = 4'd1,
        RG_RAW     = 4'd2,
        RG_IPI_SET = 4'd3,
        RG_IPI_CLR = 4'd4,
        RG_TMR_CLR = 4'd5
    } reg_idx_e;

    localparam int RG_MASK_BASE = 8;
    localparam int RG_VIEW_BASE = 12;
endpackage

// File: rtl/irq_bus_decode.sv
// Module: irq_bus_decode
// Decodes one bus request into per-function strobes and an error flag.
// Assumes: NCPU <= 4; the request lasts one cycle; no state is kept here.
module irq_bus_decode
    import irq_dispatch_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int DATA_W = 64,
    parameter int ADDR_W = 10
) (
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_size,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic [REG_IDX_W-1:0] idx,
    output logic                 acc_err,
    output logic [NCPU-1:0]      mask_we,
    output logic [NCPU-1:0]      ipi_set,
    output logic [NCPU-1:0]      ipi_clr,
    output logic [NCPU-1:0]      tmr_clr,
    output logic                 warn_clr
);
    logic            wide, mapped, read_only, dedicated, zero_sel, do_wr;
    logic [NCPU-1:0] mask_hit, view_hit, sel_vec;
    logic            unused_bits;

    assign unused_bits = ^{req_addr, req_wdata};
    assign idx         = req_addr[REG_IDX_LSB +: REG_IDX_W];
    assign wide        = (req_size == SIZE_DWORD);
    assign sel_vec     = req_wdata[NCPU-1:0];
    assign zero_sel    = (sel_vec == '0);

    // Per-processor mask and view slot hits.
    for (genvar n = 0; n < NCPU; n++) begin : g_hit
        assign mask_hit[n] = (idx == REG_IDX_W'(RG_MASK_BASE + n));
        assign view_hit[n] = (idx == REG_IDX_W'(RG_VIEW_BASE + n));
    end

    // Classify the index: mapped, read-only, and bit-mask registers.
    always_comb begin
        dedicated = (idx == RG_IPI_SET) || (idx == RG_IPI_CLR) || (idx == RG_TMR_CLR);
        read_only = (idx == RG_RAW) || (|view_hit);
        mapped    = (idx == RG_CTRL) || (idx == RG_STAT) || dedicated ||
                    read_only || (|mask_hit);
    end

    // Error on narrow size, unmapped slot, read-only write or empty bit mask.
    assign acc_err = req_valid &&
                     (!wide || !mapped ||
                      (req_write && (read_only || (dedicated && zero_sel))));
    assign do_wr   = req_valid && req_write && !acc_err;

    // Write strobes; control fields and dedicated registers merge here.
    always_comb begin
        mask_we  = do_wr ? mask_hit : '0;
        ipi_set  = '0;
        ipi_clr  = '0;
        tmr_clr  = '0;
        warn_clr = 1'b0;
        if (do_wr) begin
            unique case (idx)
                RG_CTRL: begin
                    ipi_set = req_wdata[CTL_IPI_SET_LSB +: NCPU];
                    ipi_clr = req_wdata[CTL_IPI_CLR_LSB +: NCPU];
                    tmr_clr = req_wdata[CTL_TMR_CLR_LSB +: NCPU];
                end
                RG_STAT:    warn_clr = req_wdata[0];
                RG_IPI_SET: ipi_set  = sel_vec;
                RG_IPI_CLR: ipi_clr  = sel_vec;
                RG_TMR_CLR: tmr_clr  = sel_vec;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_dev_view.sv
// Module: irq_dev_view
// Holds the registered raw request vector and, per processor, the mask and
// the masked view captured at the last mask write.
// Assumes: mask_we is already qualified (legal 64-bit write).
module irq_dev_view #(
    parameter int NCPU   = 4,
    parameter int DATA_W = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DATA_W-1:0]            dev_req,
    input  logic [NCPU-1:0]              mask_we,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            raw_q,
    output logic [NCPU-1:0][DATA_W-1:0]  mask_q,
    output logic [NCPU-1:0][DATA_W-1:0]  view_q,
    output logic [NCPU-1:0]              irq_dev
);
    // Sample the raw request vector every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= dev_req;
    end

    for (genvar n = 0; n < NCPU; n++) begin : g_cpu
        // Capture mask and recompute the view only on a mask write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[n] <= '0;
                view_q[n] <= '0;
            end else if (mask_we[n]) begin
                mask_q[n] <= wdata;
                view_q[n] <= wdata & raw_q;
            end
        end
        assign irq_dev[n] = |view_q[n];
    end
endmodule

// File: rtl/irq_pend_bank.sv
// Module: irq_pend_bank
// Pending inter-processor and timer bits plus the sticky warning flag.
// Assumes: clears apply before sets; a tick overrides a timer clear.
module irq_pend_bank #(
    parameter int NCPU = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCPU-1:0] ipi_set,
    input  logic [NCPU-1:0] ipi_clr,
    input  logic [NCPU-1:0] tmr_clr,
    input  logic            tick,
    input  logic            warn_clr,
    output logic [NCPU-1:0] ipi_q,
    output logic [NCPU-1:0] tmr_q,
    output logic            warn_q
);
    logic [NCPU-1:0] ipi_kept, ipi_d, tmr_d;
    logic            bad_req, warn_d;

    // Next-state: clear-then-set, tick wins, warning on redundant ops.
    always_comb begin
        ipi_kept = ipi_q & ~ipi_clr;
        ipi_d    = ipi_kept | ipi_set;
        tmr_d    = tick ? {NCPU{1'b1}} : (tmr_q & ~tmr_clr);
        bad_req  = (|(ipi_set & ipi_kept)) || (|(ipi_clr & ~ipi_q));
        warn_d   = bad_req || (warn_q && !warn_clr);
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ipi_q  <= '0;
            tmr_q  <= '0;
            warn_q <= 1'b0;
        end else begin
            ipi_q  <= ipi_d;
            tmr_q  <= tmr_d;
            warn_q <= warn_d;
        end
    end
endmodule

// File: rtl/irq_dispatch.sv
// Module: irq_dispatch (top)
// Memory-mapped interrupt dispatcher for up to four processors: device,
// timer and inter-processor lines, 64-bit-only register bus, one-cycle
// registered response. Assumes NCPU <= 4 and ADDR_W >= 10.
module irq_dispatch
    import irq_dispatch_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int DATA_W = 64,
    parameter int ADDR_W = 10
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req_valid,
    input  logic                                  req_write,
    input  logic [ADDR_W-1:0]                     req_addr,
    input  logic [1:0]                            req_size,
    input  logic [DATA_W-1:0]                     req_wdata,
    input  logic [((NCPU>1)?$clog2(NCPU):1)-1:0]  req_cpu,
    output logic                                  rsp_valid,
    output logic                                  rsp_err,
    output logic [DATA_W-1:0]                     rsp_rdata,
    input  logic [DATA_W-1:0]                     dev_req,
    input  logic                                  timer_tick,
    output logic [NCPU-1:0]                       irq_dev,
    output logic [NCPU-1:0]                       irq_tmr,
    output logic [NCPU-1:0]                       irq_ipi
);
    localparam int ID_W = (NCPU > 1) ? $clog2(NCPU) : 1;

    logic [REG_IDX_W-1:0]           idx;
    logic                           acc_err, warn_clr, warn_flag;
    logic [NCPU-1:0]                mask_we, ipi_set, ipi_clr, tmr_clr;
    logic [DATA_W-1:0]              raw_q, rd_d;
    logic [NCPU-1:0][DATA_W-1:0]    mask_q, view_q;

    irq_bus_decode #(.NCPU(NCPU), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .idx       (idx),
        .acc_err   (acc_err),
        .mask_we   (mask_we),
        .ipi_set   (ipi_set),
        .ipi_clr   (ipi_clr),
        .tmr_clr   (tmr_clr),
        .warn_clr  (warn_clr)
    );

    irq_dev_view #(.NCPU(NCPU), .DATA_W(DATA_W)) u_view (
        .clk     (clk),
        .rst_n   (rst_n),
        .dev_req (dev_req),
        .mask_we (mask_we),
        .wdata   (req_wdata),
        .raw_q   (raw_q),
        .mask_q  (mask_q),
        .view_q  (view_q),
        .irq_dev (irq_dev)
    );

    irq_pend_bank #(.NCPU(NCPU)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .ipi_set  (ipi_set),
        .ipi_clr  (ipi_clr),
        .tmr_clr  (tmr_clr),
        .tick     (timer_tick),
        .warn_clr (warn_clr),
        .ipi_q    (irq_ipi),
        .tmr_q    (irq_tmr),
        .warn_q   (warn_flag)
    );

    // Read mux over current state; zero on error or write.
    always_comb begin
        rd_d = '0;
        if (req_valid && !req_write && !acc_err) begin
            unique case (idx)
                RG_CTRL: begin
                    rd_d[CTL_IPI_CLR_LSB +: NCPU] = irq_ipi;
                    rd_d[CTL_TMR_CLR_LSB +: NCPU] = irq_tmr;
                    rd_d[CTL_ID_LSB +: ID_W]      = req_cpu;
                end
                RG_STAT: rd_d[0] = warn_flag;
                RG_RAW:  rd_d    = raw_q;
                default: begin
                    for (int n = 0; n < NCPU; n++) begin
                        if (idx == REG_IDX_W'(RG_MASK_BASE + n)) rd_d = mask_q[n];
                        if (idx == REG_IDX_W'(RG_VIEW_BASE + n)) rd_d = view_q[n];
                    end
                end
            endcase
        end
    end

    // Registered response, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= acc_err;
            rsp_rdata <= rd_d;
        end
    end
endmodule

// File: rtl/irq_dispatch_chk.sv
// Module: irq_dispatch_chk
// Temporal checks on the dispatcher's ports and warning flag; bound below.
module irq_dispatch_chk #(
    parameter int NCPU = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_write,
    input logic [1:0]      req_size,
    input logic            rsp_valid,
    input logic            rsp_err,
    input logic            timer_tick,
    input logic [NCPU-1:0] irq_dev,
    input logic [NCPU-1:0] irq_tmr,
    input logic [NCPU-1:0] irq_ipi,
    input logic            warn_flag
);
    p_rsp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_rsp_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_err_in_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);
    p_narrow_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != 2'd3) |=> (rsp_err && $stable(irq_ipi) && $stable(irq_dev)));
    p_tick_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timer_tick |=> (&irq_tmr));
    p_tmr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!timer_tick && !(req_valid && req_write)) |=> $stable(irq_tmr));
    p_dev_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> $stable(irq_dev));
    p_warn_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_flag && !(req_valid && req_write)) |=> warn_flag);
endmodule

bind irq_dispatch irq_dispatch_chk #(.NCPU(NCPU)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_size   (req_size),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .timer_tick (timer_tick),
    .irq_dev    (irq_dev),
    .irq_tmr    (irq_tmr),
    .irq_ipi    (irq_ipi),
    .warn_flag  (warn_flag)
);

// File: tb/sim_irq_dispatch.sv
`timescale 1ns/1ps
// Directed bench for irq_dispatch: one task per scenario.
module sim_irq_dispatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [1:0]  req_size = 2'd3;
    logic [63:0] req_wdata = '0;
    logic [1:0]  req_cpu = '0;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic [63:0] dev_req = '0;
    logic        timer_tick = 1'b0;
    logic [3:0]  irq_dev, irq_tmr, irq_ipi;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [63:0] rd;
    logic        er, vl;

    always #2 clk = ~clk;

    irq_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_cpu(req_cpu), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .dev_req(dev_req), .timer_tick(timer_tick),
        .irq_dev(irq_dev), .irq_tmr(irq_tmr), .irq_ipi(irq_ipi)
    );

    function automatic logic [9:0] ra(input int idx);
        return 10'(idx << 6);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus transfer; entered and left at a falling edge.
    task automatic xfer(input logic wr, input logic [9:0] a, input logic [63:0] d,
                        input logic [1:0] sz, input logic [1:0] cpu);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        req_size = sz; req_cpu = cpu;
        @(negedge clk);
        vl = rsp_valid; er = rsp_err; rd = rsp_rdata;
        req_valid = 1'b0; req_write = 1'b0; req_size = 2'd3;
        timer_tick = 1'b0;
    endtask

    task automatic wr64(input int idx, input logic [63:0] d);
        xfer(1'b1, ra(idx), d, 2'd3, 2'd0);
    endtask

    task automatic rd64(input int idx, input logic [1:0] cpu);
        xfer(1'b0, ra(idx), '0, 2'd3, cpu);
    endtask

    task automatic t_reset;
        chk("R12 irq_dev after reset", 64'(irq_dev), 0);
        chk("R12 irq_tmr after reset", 64'(irq_tmr), 0);
        chk("R12 irq_ipi after reset", 64'(irq_ipi), 0);
        rd64(0, 2'd2);
        chk("R3 rsp_valid on request", 64'(vl), 1);
        chk("R11 ctrl read id only", rd, 64'h2);
        @(negedge clk);
        chk("R3 rsp_valid idle", 64'(rsp_valid), 0);
        rd64(8, 2'd0);
        chk("R12 mask0 reset", rd, 0);
    endtask

    task automatic t_mask;
        dev_req = 64'hF0;
        @(negedge clk);
        wr64(8, 64'h0F);
        chk("R4 disjoint mask no irq", 64'(irq_dev), 0);
        chk("R4 mask write no err", 64'(er), 0);
        wr64(9, 64'h10);
        chk("R4 overlap raises cpu1", 64'(irq_dev), 64'b0010);
        rd64(13, 2'd0);
        chk("R4 view1 readback", rd, 64'h10);
        rd64(9, 2'd0);
        chk("R4 mask1 readback", rd, 64'h10);
        wr64(9, 64'h0);
        chk("R4 clearing mask drops cpu1", 64'(irq_dev), 0);
        xfer(1'b1, ra(8) | 10'h18, 64'h80, 2'd3, 2'd0);
        chk("R1 low offset bits ignored", 64'(irq_dev), 64'b0001);
        rd64(8, 2'd0);
        chk("R1 mask0 via slot base", rd, 64'h80);
        wr64(8, 64'h0);
    endtask

    task automatic t_raw;
        wr64(10, 64'h100);
        chk("R4 mask2 no overlap", 64'(irq_dev), 0);
        dev_req = 64'h100;
        repeat (3) @(negedge clk);
        chk("R5 raw change alone no irq", 64'(irq_dev), 0);
        rd64(14, 2'd0);
        chk("R5 view2 unchanged", rd, 0);
        rd64(2, 2'd0);
        chk("R11 raw readback", rd, 64'h100);
        wr64(10, 64'h100);
        chk("R5 rewrite mask picks up raw", 64'(irq_dev), 64'b0100);
        wr64(10, 64'h0);
    endtask

    task automatic t_ipi;
        wr64(0, 64'h5000);
        chk("R6 ctrl sets ipi 0 and 2", 64'(irq_ipi), 64'b0101);
        rd64(0, 2'd1);
        chk("R11 ctrl read pending and id", rd, 64'h501);
        wr64(0, 64'h0100);
        chk("R6 ctrl clears ipi 0", 64'(irq_ipi), 64'b0100);
        rd64(1, 2'd0);
        chk("R7 no warning yet", rd, 0);
    endtask

    task automatic t_warn;
        wr64(0, 64'h4000);
        chk("R7 duplicate set keeps state", 64'(irq_ipi), 64'b0100);
        rd64(1, 2'd0);
        chk("R7 duplicate set warns", rd, 1);
        wr64(1, 64'h1);
        rd64(1, 2'd0);
        chk("R7 warning cleared by write", rd, 0);
        wr64(0, 64'h0200);
        chk("R7 empty clear keeps state", 64'(irq_ipi), 64'b0100);
        rd64(1, 2'd0);
        chk("R7 empty clear warns", rd, 1);
        wr64(1, 64'h1);
        wr64(0, 64'h4400);
        chk("R6 clear then set same write", 64'(irq_ipi), 64'b0100);
        rd64(1, 2'd0);
        chk("R7 clear-then-set no warning", rd, 0);
        wr64(0, 64'h0400);
        chk("R6 ipi all clear", 64'(irq_ipi), 0);
    endtask

    task automatic t_timer;
        timer_tick = 1'b1;
        @(negedge clk);
        timer_tick = 1'b0;
        chk("R8 tick sets all timers", 64'(irq_tmr), 64'hF);
        wr64(0, 64'h0030);
        chk("R6 ctrl clears timers 0,1", 64'(irq_tmr), 64'b1100);
        timer_tick = 1'b1;
        wr64(0, 64'h00C0);
        chk("R8 tick beats same-cycle clear", 64'(irq_tmr), 64'hF);
        wr64(0, 64'h00F0);
        chk("R6 all timers cleared", 64'(irq_tmr), 0);
    endtask

    task automatic t_nxm;
        wr64(0, 64'h1000);
        wr64(0, 64'h1000_0000);
        chk("R9 bit 28 no error", 64'(er), 0);
        chk("R9 bit 28 ipi untouched", 64'(irq_ipi), 64'b0001);
        chk("R9 bit 28 timer untouched", 64'(irq_tmr), 0);
    endtask

    task automatic t_dedicated;
        wr64(3, 64'h2);
        chk("R10 set register", 64'(irq_ipi), 64'b0011);
        wr64(4, 64'h1);
        chk("R10 clear register", 64'(irq_ipi), 64'b0010);
        timer_tick = 1'b1;
        @(negedge clk);
        timer_tick = 1'b0;
        wr64(5, 64'h1);
        chk("R10 timer clear register", 64'(irq_tmr), 64'b1110);
        wr64(3, 64'h0);
        chk("R10 zero set is error", 64'(er), 1);
        chk("R10 zero set no change", 64'(irq_ipi), 64'b0010);
        wr64(5, 64'h0);
        chk("R10 zero timer clear is error", 64'(er), 1);
        chk("R10 zero timer clear no change", 64'(irq_tmr), 64'b1110);
    endtask

    task automatic t_narrow;
        xfer(1'b1, ra(0), 64'h8000, 2'd2, 2'd0);
        chk("R2 narrow ctrl write error", 64'(er), 1);
        chk("R2 narrow ctrl write no change", 64'(irq_ipi), 64'b0010);
        xfer(1'b1, ra(11), 64'h100, 2'd0, 2'd0);
        chk("R2 narrow mask write error", 64'(er), 1);
        chk("R2 narrow mask write no irq", 64'(irq_dev), 0);
        rd64(11, 2'd0);
        chk("R2 mask3 still zero", rd, 0);
        xfer(1'b0, ra(0), '0, 2'd1, 2'd3);
        chk("R2 narrow read error", 64'(er), 1);
        chk("R2 narrow read data zero", rd, 0);
    endtask

    task automatic t_map;
        wr64(6, 64'h1);
        chk("R13 unmapped write error", 64'(er), 1);
        rd64(7, 2'd0);
        chk("R13 unmapped read error", 64'(er), 1);
        wr64(12, 64'h1);
        chk("R13 view write error", 64'(er), 1);
        rd64(12, 2'd0);
        chk("R13 view0 unchanged", rd, 0);
        wr64(2, 64'h0);
        chk("R13 raw write error", 64'(er), 1);
        rd64(2, 2'd0);
        chk("R13 raw still sampled", rd, 64'h100);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_raw();
        t_ipi();
        t_warn();
        t_timer();
        t_nxm();
        t_dedicated();
        t_narrow();
        t_map();
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule